// File: doc/BRIEF.md
# External SRAM Bus Controller with Shared Address/Data Port

This block sits between a core's load/store path and a pair of 8-bit I/O ports. When the external-memory enable is set, every request whose address lies at or above the external base (default `0x0260`) becomes a cycle on a multiplexed bus. In that cycle the low address byte and the data take turns on one 8-bit port, and the high address byte is held on a second 8-bit port. An address-latch-enable strobe (`ale`, active high) lets an outside transparent latch capture the low address byte. Active-low read and write strobes (`rd_n`, `wr_n`) then run the SRAM. Requests below the base are internal, and the controller ignores them.

An access is three cycles long: address, strobe, done. Setting `wait_en` when the request is accepted adds one more strobe cycle. The request fields are latched when the request is accepted. A new request is taken only while the controller is idle. When the enable is clear, both ports simply show the ordinary port output values and directions.

Top module: `xsram_bus_ctrl`

## Requirements
- R1: After reset the controller is idle: `ale`=0, `rd_n`=1, `wr_n`=1, `done`=0, `rdata`=0x00.
- R2: An external request (`xmem_en`=1, `addr` ≥ 0x0260) seen while idle is accepted on that clock edge. In the following cycle `ale`=1, `pa_out`=`addr[7:0]` and `pc_out`=`addr[15:8]`.
- R3: With `wait_en`=0 at acceptance, exactly one strobe cycle follows the address cycle. `done` is 1 in the third cycle.
- R4: With `wait_en`=1 at acceptance, exactly two strobe cycles follow the address cycle. `done` is 1 in the fourth cycle.
- R5: For a write (`we`=1), every strobe cycle has `wr_n`=0, `rd_n`=1, `pa_out`=write data and `pa_oe`=0xFF.
- R6: For a read (`we`=0), every strobe cycle has `rd_n`=0, `wr_n`=1 and `pa_oe`=0x00. `rdata` takes the value of `pa_in` in the last strobe cycle, is valid in the done cycle, and holds until the next read completes.
- R7: `ale` is 0 from the first strobe cycle through the done cycle. In the done cycle both strobes are 1 and `pa_out` is back to the low address byte.
- R8: A request with `addr` < 0x0260 produces no `ale`, no strobe and no `done`.
- R9: With `xmem_en`=0: `pa_out`/`pa_oe` equal `port_lo_out`/`port_lo_dir`; `pc_out`/`pc_oe` equal `port_hi_out`/`port_hi_dir`; requests are ignored and `ale`, `rd_n`, `wr_n` stay inactive.
- R10: With `xmem_en`=1, `pc_oe` is 0xFF regardless of the port direction inputs. `pa_oe` is also 0xFF except during read strobe cycles.
- R11: Inputs that change while an access is in progress (request, address, data, direction, wait bit) do not alter it. No request is accepted before the controller returns to idle.
- R12: `done` is a single-cycle pulse, given once per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| xmem_en | input | 1 | External memory enable |
| wait_en | input | 1 | Add one strobe cycle |
| port_lo_out | input | 8 | Ordinary low-port output value |
| port_lo_dir | input | 8 | Ordinary low-port direction (1 = drive) |
| port_hi_out | input | 8 | Ordinary high-port output value |
| port_hi_dir | input | 8 | Ordinary high-port direction |
| pa_in | input | 8 | Value read back from the shared port pins |
| pa_out | output | 8 | Shared port output (low address / data) |
| pa_oe | output | 8 | Shared port per-bit output enable |
| pc_out | output | 8 | High address port output |
| pc_oe | output | 8 | High address port per-bit output enable |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Read data |
| done | output | 1 | Access complete pulse |

## Verification
A wrong sequencer state appears on the pins in the cycle after the bad transition. Examples are a missing or extra strobe cycle, `ale` arriving at the wrong time, or `done` firing early. This is caught because every cycle of every access is compared, and the cycle count is taken from the wait bit latched at acceptance. A corrupted request latch shows up as a wrong low address on `pa_out` in the address or done cycle, or as data written to the wrong SRAM location. Either makes a later read return a value that differs from the bench's reference memory. A wrong read capture shows in `rdata` in the done cycle. A wrong boundary compare or a wrong enable mux shows at once in the internal-address and disabled-mode cycles.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_DATA,
        ST_DONE
    } xmb_state_e;

    typedef struct packed {
        logic              we;
        logic              stretch;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xmb_req_t;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic [DATA_W-1:0] lo_out;
        logic [DATA_W-1:0] lo_oe;
        logic [HI_W-1:0]   hi_out;
        logic [HI_W-1:0]   hi_oe;
    } xmb_pins_t;

    function automatic logic in_strobe(xmb_state_e s);
        return (s == ST_HOLD) || (s == ST_DATA);
    endfunction

    function automatic logic hits_external(logic [ADDR_W-1:0] a,
                                           logic [ADDR_W-1:0] base,
                                           logic              en);
        return en && (a >= base);
    endfunction
endpackage

// File: rtl/xmb_decode.sv
module xmb_decode
    import xmb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EXT_BASE = 16'h0260
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              xmem_en,
    input  logic              idle,
    output logic              go
);
    always_comb begin
        go = req && idle && hits_external(addr, EXT_BASE, xmem_en);
    end
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  xmb_req_t          req_in,
    input  logic [DATA_W-1:0] pa_in,
    output xmb_state_e        state,
    output xmb_req_t          lat,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    xmb_state_e state_q;
    xmb_req_t   lat_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lat_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        lat_q   <= req_in;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= lat_q.stretch ? ST_HOLD : ST_DATA;
                ST_HOLD: state_q <= ST_DATA;
                ST_DATA: begin
                    if (!lat_q.we) begin
                        rdata_q <= pa_in;
                    end
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state = state_q;
    assign lat   = lat_q;
    assign rdata = rdata_q;
    assign done  = (state_q == ST_DONE);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_latch_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> $stable(lat_q.addr) && $stable(lat_q.wdata));
    p_stretch_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && lat_q.stretch) |=> (state_q == ST_HOLD));
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DATA) |=> $stable(rdata_q));
endmodule

// File: rtl/xmb_pinmux.sv
module xmb_pinmux
    import xmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xmem_en,
    input  xmb_state_e        state,
    input  xmb_req_t          lat,
    input  logic [DATA_W-1:0] port_lo_out,
    input  logic [DATA_W-1:0] port_lo_dir,
    input  logic [HI_W-1:0]   port_hi_out,
    input  logic [HI_W-1:0]   port_hi_dir,
    output xmb_pins_t         pins
);
    always_comb begin
        pins.ale    = 1'b0;
        pins.rd_n   = 1'b1;
        pins.wr_n   = 1'b1;
        pins.lo_out = lat.addr[DATA_W-1:0];
        pins.lo_oe  = '1;
        pins.hi_out = lat.addr[ADDR_W-1:DATA_W];
        pins.hi_oe  = '1;
        if (!xmem_en) begin
            pins.lo_out = port_lo_out;
            pins.lo_oe  = port_lo_dir;
            pins.hi_out = port_hi_out;
            pins.hi_oe  = port_hi_dir;
        end else if (state == ST_ADDR) begin
            pins.ale = 1'b1;
        end else if (in_strobe(state)) begin
            if (lat.we) begin
                pins.wr_n   = 1'b0;
                pins.lo_out = lat.wdata;
            end else begin
                pins.rd_n  = 1'b0;
                pins.lo_oe = '0;
            end
        end
    end

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!pins.rd_n && !pins.wr_n));
    p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
        !pins.rd_n |-> (pins.lo_oe == '0));
    p_ale_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        pins.ale |-> (pins.rd_n && pins.wr_n));
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !xmem_en |-> (!pins.ale && pins.rd_n && pins.wr_n));
endmodule

// File: rtl/xsram_bus_ctrl.sv
module xsram_bus_ctrl
    import xmb_pkg::*;
#(
    parameter logic [15:0] EXT_BASE = 16'h0260
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        xmem_en,
    input  logic        wait_en,
    input  logic [7:0]  port_lo_out,
    input  logic [7:0]  port_lo_dir,
    input  logic [7:0]  port_hi_out,
    input  logic [7:0]  port_hi_dir,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe,
    output logic        ale,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  rdata,
    output logic        done
);
    xmb_state_e state;
    xmb_req_t   lat;
    xmb_req_t   req_in;
    xmb_pins_t  pins;
    logic       go;

    always_comb begin
        req_in.we      = we;
        req_in.stretch = wait_en;
        req_in.addr    = addr;
        req_in.wdata   = wdata;
    end

    xmb_decode #(.EXT_BASE(EXT_BASE)) u_decode (
        .req     (req),
        .addr    (addr),
        .xmem_en (xmem_en),
        .idle    (state == ST_IDLE),
        .go      (go)
    );

    xmb_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .req_in (req_in),
        .pa_in  (pa_in),
        .state  (state),
        .lat    (lat),
        .rdata  (rdata),
        .done   (done)
    );

    xmb_pinmux u_pinmux (
        .clk         (clk),
        .rst         (rst),
        .xmem_en     (xmem_en),
        .state       (state),
        .lat         (lat),
        .port_lo_out (port_lo_out),
        .port_lo_dir (port_lo_dir),
        .port_hi_out (port_hi_out),
        .port_hi_dir (port_hi_dir),
        .pins        (pins)
    );

    assign pa_out = pins.lo_out;
    assign pa_oe  = pins.lo_oe;
    assign pc_out = pins.hi_out;
    assign pc_oe  = pins.hi_oe;
    assign ale    = pins.ale;
    assign rd_n   = pins.rd_n;
    assign wr_n   = pins.wr_n;

    p_internal_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req && addr < EXT_BASE) |=> !ale);
endmodule

// File: tb/test_xsram_bus_ctrl.sv
module test_xsram_bus_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, we_i = 1'b0, xmem_en = 1'b1, wait_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0] wdata = '0, port_lo_out = '0, port_lo_dir = '0, port_hi_out = '0, port_hi_dir = '0;
    logic [7:0] pa_in, pa_out, pa_oe, pc_out, pc_oe, rdata;
    logic ale, rd_n, wr_n, done;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] sram    [256];
    logic [7:0] ref_mem [256];
    logic [7:0] latch_lo = '0;
    logic [7:0] last_rd  = '0;

    always #2.5 clk = ~clk;

    xsram_bus_ctrl i_xsram_bus_ctrl (
        .clk(clk), .rst(rst), .req(req), .we(we_i), .addr(addr), .wdata(wdata),
        .xmem_en(xmem_en), .wait_en(wait_en),
        .port_lo_out(port_lo_out), .port_lo_dir(port_lo_dir),
        .port_hi_out(port_hi_out), .port_hi_dir(port_hi_dir),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pc_out(pc_out), .pc_oe(pc_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .done(done)
    );

    // External transparent latch and SRAM, bench-only
    always @(posedge clk) if (ale) latch_lo <= pa_out;
    always @(posedge clk) if (!wr_n) sram[latch_lo ^ pc_out] <= pa_out;
    assign pa_in = !rd_n ? sram[latch_lo ^ pc_out] : 8'h00;

    function automatic logic [7:0] ref_idx(logic [15:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    function automatic logic is_ext(logic [15:0] a);
        return a >= 16'h0260;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic access(input logic w, input logic [15:0] a, input logic [7:0] d,
                          input logic st, input logic hold);
        @(negedge clk);
        req = 1'b1; we_i = w; addr = a; wdata = d; wait_en = st;
        @(negedge clk);
        if (hold) begin
            addr = ~a; wdata = ~d; we_i = ~w; wait_en = ~st; port_hi_dir = 8'h00;
        end else req = 1'b0;
        chk(ale == 1'b1, "R2 ale", {31'd0, ale}, 1);
        chk(pa_out == a[7:0], "R2 low addr", {24'd0, pa_out}, {24'd0, a[7:0]});
        chk(pc_out == a[15:8], "R2 high addr", {24'd0, pc_out}, {24'd0, a[15:8]});
        chk(pa_oe == 8'hFF && pc_oe == 8'hFF, "R10 oe", {16'd0, pa_oe, pc_oe}, 32'hFFFF);
        for (int i = 0; i < (st ? 2 : 1); i++) begin
            @(negedge clk);
            chk(ale == 1'b0, "R7 ale low", {31'd0, ale}, 0);
            chk(done == 1'b0, st ? "R4 no early done" : "R3 no early done", {31'd0, done}, 0);
            if (w) begin
                chk(wr_n == 1'b0 && rd_n == 1'b1, "R5 strobes", {30'd0, rd_n, wr_n}, 32'h2);
                chk(pa_out == d && pa_oe == 8'hFF, "R5 data", {16'd0, pa_oe, pa_out}, {16'd0, 8'hFF, d});
            end else begin
                chk(rd_n == 1'b0 && wr_n == 1'b1, "R6 strobes", {30'd0, rd_n, wr_n}, 32'h1);
                chk(pa_oe == 8'h00, "R6 release", {24'd0, pa_oe}, 0);
            end
        end
        @(negedge clk);
        if (hold) begin
            req = 1'b0; port_hi_dir = 8'h00;
        end
        chk(done == 1'b1, st ? "R4 done" : "R3 done", {31'd0, done}, 1);
        chk(pa_out == a[7:0] && pa_oe == 8'hFF, "R7 addr back", {16'd0, pa_oe, pa_out}, {16'd0, 8'hFF, a[7:0]});
        chk(ale == 1'b0 && rd_n && wr_n, "R7 quiet", {29'd0, ale, rd_n, wr_n}, 32'h3);
        if (w) ref_mem[ref_idx(a)] = d;
        else last_rd = ref_mem[ref_idx(a)];
        chk(rdata == last_rd, "R6 rdata", {24'd0, rdata}, {24'd0, last_rd});
        @(negedge clk);
        chk(done == 1'b0, "R12 pulse", {31'd0, done}, 0);
        chk(ale == 1'b0, "R11 no accept while busy", {31'd0, ale}, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            sram[i]    = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ale == 0 && rd_n && wr_n, "R1 strobes", {29'd0, ale, rd_n, wr_n}, 32'h3);
        chk(done == 0, "R1 done", {31'd0, done}, 0);
        chk(rdata == 0, "R1 rdata", {24'd0, rdata}, 0);
        chk(pa_oe == 8'hFF && pc_oe == 8'hFF, "R10 idle oe", {16'd0, pa_oe, pc_oe}, 32'hFFFF);

        // Boundary: just below base is internal
        @(negedge clk);
        req = 1'b1; addr = 16'h025F; we_i = 1'b0;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(ale == 0 && rd_n && wr_n && !done, "R8 internal ignored",
                {28'd0, ale, rd_n, wr_n, done}, 32'h6);
            @(negedge clk);
        end

        // First external address, both lengths, read after write
        access(1'b1, 16'h0260, 8'h3C, 1'b0, 1'b0);
        access(1'b0, 16'h0260, 8'h00, 1'b1, 1'b0);
        access(1'b1, 16'hFFFF, 8'hC5, 1'b1, 1'b0);
        access(1'b0, 16'hFFFF, 8'h00, 1'b0, 1'b0);
        // Write after read leaves rdata alone (checked in done cycle)
        access(1'b1, 16'h1234, 8'h99, 1'b0, 1'b0);
        // Inputs toggled while busy
        access(1'b1, 16'h4321, 8'h5A, 1'b0, 1'b1);
        access(1'b0, 16'h4321, 8'h00, 1'b1, 1'b1);

        // Disabled: ordinary port behaviour
        @(negedge clk);
        xmem_en = 1'b0; port_lo_out = 8'hA5; port_lo_dir = 8'h3C;
        port_hi_out = 8'h5A; port_hi_dir = 8'hC3;
        req = 1'b1; addr = 16'h8000; we_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(pa_out == 8'hA5 && pa_oe == 8'h3C, "R9 low port", {16'd0, pa_out, pa_oe}, 32'hA53C);
            chk(pc_out == 8'h5A && pc_oe == 8'hC3, "R9 high port", {16'd0, pc_out, pc_oe}, 32'h5AC3);
            chk(!ale && rd_n && wr_n && !done, "R9 no strobes", {28'd0, ale, rd_n, wr_n, done}, 32'h6);
        end
        req = 1'b0; xmem_en = 1'b1; port_lo_dir = 8'h00; port_hi_dir = 8'h00;
        @(negedge clk);
        chk(pa_oe == 8'hFF && pc_oe == 8'hFF, "R10 override", {16'd0, pa_oe, pc_oe}, 32'hFFFF);

        // Constrained random mix
        for (int k = 0; k < 60; k++) begin
            logic [15:0] a;
            a = 16'h0260 + 16'($urandom % (32'h10000 - 32'h0260));
            access(1'($urandom), a, 8'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule